// File: doc/BRIEF.md
# USB IN Endpoint Transmit Transfer Sequencer

This block sequences transmit transfers for the IN endpoints of a USB device. It has a configurable number of independent channels, three by default. Each channel holds a 16-bit control word with a counting-mode bit, a self-clearing launch bit and a transfer size. Once launched, a channel answers every IN token with a packet request and the byte count the packetizer must send, zero-length packets included. It counts the remaining amount down each time the packetizer acknowledges that a packet went out. When the transfer completes, it raises a sticky completion flag.

The size is counted either in bytes or in whole endpoint buffers. In buffer mode a size of zero stands for the largest run, 2^SZW buffers. In byte mode a size of zero sends one empty packet. A byte count that is an exact multiple of the endpoint buffer size is closed by an extra empty packet. A running transfer ignores register writes and can only be aborted by the endpoint-clear input. USB bus reset clears every channel as the system reset does.

Top module: `usb_in_xfer_seq`

## Requirements
- R1: Control word layout: bit 15 is the mode (1 = size in bytes, 0 = size in endpoint buffers), bit 14 is launch, bits 9:0 are the size. Bits 14:10 always read 0. `reg_addr` selects channel 0..NCH-1, and a read of any other address returns 0.
- R2: A write while the channel is idle loads mode and size. If bit 14 of that write is 1, the transfer starts. If bit 14 is 0, no transfer starts and IN tokens stay unanswered.
- R3: While a transfer is active, register writes to that channel are ignored: the mode, the size and the launch bit all keep their values.
- R4: The size field reads back the bytes or buffers still to be sent, and reads 0 once a transfer completes.
- R5: In buffer mode every packet carries the full endpoint buffer size. A size of 0 means 1024 buffers, and the field then reads 0, 0x3FF, 0x3FE, ..., 1, 0.
- R6: In byte mode each packet carries the smaller of the remaining bytes and the buffer size. The transfer completes with the first packet that is shorter than the buffer size.
- R7: In byte mode a byte count that is an exact multiple of the buffer size is followed by one zero-length packet before completion. A size of 0 yields exactly one zero-length packet and then completion.
- R8: An IN token is taken only by an active channel with no packet outstanding. `pkt_req` rises the cycle after the token and falls the cycle after `pkt_ack`. `pkt_len` holds steady while `pkt_req` is high. The count changes only on an acknowledge.
- R9: `done_irq` rises the cycle after the acknowledge of the final packet and stays high until a `done_clr` pulse for that channel.
- R10: `ep_clr` aborts the channel: the request drops, the transfer becomes idle, the size reads 0, and no completion is flagged.
- R11: `bus_rst`, like `rst_n`, clears every field, request and completion flag of all channels.
- R12: The endpoint buffer size is sampled when the transfer starts. Later changes to `ep_bufsz` do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | USB bus reset, synchronous clear of all channels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Channel select for read and write |
| reg_wdata | input | 16 | Write data (control word) |
| reg_rdata | output | 16 | Read data for the selected channel |
| done_clr | input | NCH | Write-one-to-clear strobes for the completion flags |
| ep_bufsz | input | NCH*SZW | Endpoint buffer size per channel, 8..1023 |
| ep_clr | input | NCH | Endpoint clear (abort) per channel |
| in_tok | input | NCH | IN token strobe per channel |
| pkt_req | output | NCH | Packet request outstanding per channel |
| pkt_len | output | NCH*SZW | Byte count of the requested packet per channel |
| pkt_ack | input | NCH | Packet-sent acknowledge per channel |
| done_irq | output | NCH | Sticky completion flag per channel |

## Verification
The bench builds the block with its default parameters: NCH = 3 and SZW = 10. With these values all three channels run side by side, and the full 1024-buffer run of a zero size in buffer mode is short enough to play out completely. An 8-byte buffer size gives byte transfers of several packets, including one that ends on an exact multiple and one that ends on a short packet. A 64-byte size in buffer mode shows that the latched buffer size, not the remaining count, sets the packet length.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;
  localparam int REG_W     = 16;
  localparam int MODE_BIT  = 15;
  localparam int START_BIT = 14;

  typedef enum logic {
    CNT_BUFS  = 1'b0,
    CNT_BYTES = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/usb_in_chan.sv
module usb_in_chan
  import usb_in_pkg::*;
#(
  parameter int SZW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic [SZW-1:0]   ep_bufsz,
  input  logic             ep_clr,
  input  logic             in_tok,
  input  logic             pkt_ack,
  input  logic             done_clr,
  output logic             pkt_req,
  output logic [SZW-1:0]   pkt_len,
  output logic             done,
  output logic [REG_W-1:0] rd_word
);
  localparam int RW = SZW + 1;
  localparam logic [RW-1:0] FULL_RUN = {1'b1, {SZW{1'b0}}};
  localparam logic [RW-1:0] ONE_LEFT = RW'(1);

  logic            act_q, act_d;
  logic            pend_q, pend_d;
  logic            done_q, done_d;
  cnt_mode_e       mode_q, mode_d;
  logic [RW-1:0]   rem_q, rem_d;
  logic [SZW-1:0]  bsz_q, bsz_d;
  logic [SZW-1:0]  len_q, len_d;

  logic [SZW-1:0]  wr_size;
  cnt_mode_e       wr_mode;
  logic            wr_go;
  logic [SZW-1:0]  byte_len;
  logic            short_pkt;
  logic            last_buf;
  logic            take_tok;
  logic            take_ack;

  always_comb begin
    wr_size   = wdata[SZW-1:0];
    wr_mode   = cnt_mode_e'(wdata[MODE_BIT]);
    wr_go     = wdata[START_BIT];
    byte_len  = (rem_q < {1'b0, bsz_q}) ? rem_q[SZW-1:0] : bsz_q;
    short_pkt = len_q < bsz_q;
    last_buf  = rem_q == ONE_LEFT;
    take_tok  = act_q && !pend_q && in_tok;
    take_ack  = pend_q && pkt_ack;
  end

  // next-state process
  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    done_d = done_q;
    mode_d = mode_q;
    rem_d  = rem_q;
    bsz_d  = bsz_q;
    len_d  = len_q;

    if (done_clr) begin
      done_d = 1'b0;
    end

    if (wr_hit && !act_q) begin
      mode_d = wr_mode;
      rem_d  = {1'b0, wr_size};
      if (wr_go) begin
        act_d = 1'b1;
        bsz_d = ep_bufsz;
        if (wr_mode == CNT_BUFS && wr_size == '0) begin
          rem_d = FULL_RUN;
        end
      end
    end

    if (take_tok) begin
      pend_d = 1'b1;
      len_d  = (mode_q == CNT_BYTES) ? byte_len : bsz_q;
    end

    if (take_ack) begin
      pend_d = 1'b0;
      if (mode_q == CNT_BYTES) begin
        rem_d = rem_q - {1'b0, len_q};
        if (short_pkt) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end
      end else begin
        rem_d = rem_q - ONE_LEFT;
        if (last_buf) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end
      end
    end

    if (ep_clr) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
      rem_d  = '0;
      done_d = done_q && !done_clr;
    end

    if (bus_rst) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
      done_d = 1'b0;
      mode_d = CNT_BUFS;
      rem_d  = '0;
      bsz_d  = '0;
      len_d  = '0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= CNT_BUFS;
      rem_q  <= '0;
      bsz_q  <= '0;
      len_q  <= '0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      done_q <= done_d;
      mode_q <= mode_d;
      rem_q  <= rem_d;
      bsz_q  <= bsz_d;
      len_q  <= len_d;
    end
  end

  always_comb begin
    rd_word              = '0;
    rd_word[MODE_BIT]    = mode_q;
    rd_word[SZW-1:0]     = rem_q[SZW-1:0];
  end

  assign pkt_req = pend_q;
  assign pkt_len = len_q;
  assign done    = done_q;
endmodule

// File: rtl/usb_in_regmux.sv
module usb_in_regmux
  import usb_in_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [NCH*REG_W-1:0] words,
  output logic [NCH-1:0]       wr_hit,
  output logic [REG_W-1:0]     rdata
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_dec
      assign wr_hit[g] = reg_wr && (reg_addr == AW'(g));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == AW'(i)) begin
        rdata = words[i*REG_W +: REG_W];
      end
    end
  end
endmodule

// File: rtl/usb_in_xfer_seq.sv
module usb_in_xfer_seq
  import usb_in_pkg::*;
#(
  parameter int NCH = 3,
  parameter int SZW = 10,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rst,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NCH-1:0]     done_clr,
  input  logic [NCH*SZW-1:0] ep_bufsz,
  input  logic [NCH-1:0]     ep_clr,
  input  logic [NCH-1:0]     in_tok,
  output logic [NCH-1:0]     pkt_req,
  output logic [NCH*SZW-1:0] pkt_len,
  input  logic [NCH-1:0]     pkt_ack,
  output logic [NCH-1:0]     done_irq
);
  logic [NCH-1:0]       wr_hit;
  logic [NCH*REG_W-1:0] words;

  usb_in_regmux #(.NCH(NCH), .AW(AW)) u_regmux (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .words    (words),
    .wr_hit   (wr_hit),
    .rdata    (reg_rdata)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      usb_in_chan #(.SZW(SZW)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rst  (bus_rst),
        .wr_hit   (wr_hit[g]),
        .wdata    (reg_wdata),
        .ep_bufsz (ep_bufsz[g*SZW +: SZW]),
        .ep_clr   (ep_clr[g]),
        .in_tok   (in_tok[g]),
        .pkt_ack  (pkt_ack[g]),
        .done_clr (done_clr[g]),
        .pkt_req  (pkt_req[g]),
        .pkt_len  (pkt_len[g*SZW +: SZW]),
        .done     (done_irq[g]),
        .rd_word  (words[g*REG_W +: REG_W])
      );
    end
  endgenerate
endmodule

// File: rtl/usb_in_xfer_seq_chk.sv
module usb_in_xfer_seq_chk #(
  parameter int NCH = 3,
  parameter int SZW = 10,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rst,
  input logic               reg_wr,
  input logic [AW-1:0]      reg_addr,
  input logic [15:0]        reg_wdata,
  input logic [15:0]        reg_rdata,
  input logic [NCH-1:0]     done_clr,
  input logic [NCH*SZW-1:0] ep_bufsz,
  input logic [NCH-1:0]     ep_clr,
  input logic [NCH-1:0]     in_tok,
  input logic [NCH-1:0]     pkt_req,
  input logic [NCH*SZW-1:0] pkt_len,
  input logic [NCH-1:0]     pkt_ack,
  input logic [NCH-1:0]     done_irq
);
  assert_busrst_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (done_irq == '0 && pkt_req == '0));

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pkt_req[g]) |-> $past(pkt_ack[g] || ep_clr[g] || bus_rst));

      assert_len_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req[g] && $past(pkt_req[g])) |-> $stable(pkt_len[g*SZW +: SZW]));

      assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq[g]) |-> $past(pkt_ack[g] && pkt_req[g]));

      assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_irq[g]) |-> $past(done_clr[g] || bus_rst));

      assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_clr[g] && !done_irq[g]) |=> (!done_irq[g] && !pkt_req[g]));
    end
  endgenerate
endmodule

bind usb_in_xfer_seq usb_in_xfer_seq_chk #(.NCH(NCH), .SZW(SZW)) u_chk (.*);

// File: tb/usb_in_xfer_seq_bench.sv
module usb_in_xfer_seq_bench;
  localparam int CLK_P = 10;
  localparam int NCH   = 3;
  localparam int SZW   = 10;

  logic             clk;
  logic             rst_n;
  logic             bus_rst;
  logic             reg_wr;
  logic [1:0]       reg_addr;
  logic [15:0]      reg_wdata;
  logic [15:0]      reg_rdata;
  logic [NCH-1:0]   done_clr;
  logic [NCH*SZW-1:0] ep_bufsz;
  logic [NCH-1:0]   ep_clr;
  logic [NCH-1:0]   in_tok;
  logic [NCH-1:0]   pkt_req;
  logic [NCH*SZW-1:0] pkt_len;
  logic [NCH-1:0]   pkt_ack;
  logic [NCH-1:0]   done_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;
  int    sb_q[$];
  string tag_q[$];
  logic [NCH-1:0] prev_req;

  usb_in_xfer_seq #(.NCH(NCH), .SZW(SZW)) u_usb_in_xfer_seq (.*);

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected packets as requests appear
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (pkt_req[c] && !prev_req[c]) begin
          if (sb_q.size() == 0) begin
            chk(0, "R8 unexpected packet request", c, -1);
          end else begin
            int e;
            string t;
            e = sb_q.pop_front();
            t = tag_q.pop_front();
            chk(e == c*4096 + int'(pkt_len[c*SZW +: SZW]), t,
                c*4096 + int'(pkt_len[c*SZW +: SZW]), e);
          end
        end
      end
    end
    prev_req = pkt_req;
  end

  task automatic wr(int ch, logic [15:0] v);
    @(negedge clk);
    reg_addr  = 2'(ch);
    reg_wdata = v;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_chk(int ch, logic [15:0] exp, string tag);
    reg_addr = 2'(ch);
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic set_bsz(int ch, int v);
    ep_bufsz[ch*SZW +: SZW] = SZW'(v);
  endtask

  task automatic tok(int ch);
    @(negedge clk); in_tok[ch] = 1'b1;
    @(negedge clk); in_tok[ch] = 1'b0;
  endtask

  task automatic ack(int ch);
    @(negedge clk); pkt_ack[ch] = 1'b1;
    @(negedge clk); pkt_ack[ch] = 1'b0;
  endtask

  // driver: push expected length, play token and acknowledge
  task automatic send(int ch, int explen, string tag);
    sb_q.push_back(ch*4096 + explen);
    tag_q.push_back(tag);
    tok(ch);
    ack(ch);
    #1;
  endtask

  task automatic pulse_clr(int ch);
    @(negedge clk); done_clr[ch] = 1'b1;
    @(negedge clk); done_clr[ch] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_rst = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    done_clr = '0; ep_clr = '0; in_tok = '0; pkt_ack = '0; prev_req = '0;
    ep_bufsz = '0;
    set_bsz(0, 8); set_bsz(1, 8); set_bsz(2, 64);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int c = 0; c < NCH; c++) rd_chk(c, 16'h0000, "R11 reset readback");
    chk(done_irq == 0 && pkt_req == 0, "R11 reset outputs", {done_irq, pkt_req}, 0);
    rd_chk(3, 16'h0000, "R1 unmapped address");

    // R2 load without launch
    wr(0, 16'h8005);
    rd_chk(0, 16'h8005, "R2 fields load");
    tok(0); #1;
    chk(pkt_req[0] == 0, "R2 R8 no launch, token ignored", pkt_req[0], 0);

    // R6 R4 byte mode with short last packet; R1 layout
    wr(0, 16'hC014);
    rd_chk(0, 16'h8014, "R1 start bit reads 0");
    send(0, 8, "R6 packet 1 length");
    rd_chk(0, 16'h800C, "R4 remaining after packet 1");
    send(0, 8, "R6 packet 2 length");
    rd_chk(0, 16'h8004, "R4 remaining after packet 2");
    chk(done_irq[0] == 0, "R9 not done early", done_irq[0], 0);
    send(0, 4, "R6 short packet length");
    chk(done_irq[0] == 1, "R6 R9 done after short packet", done_irq[0], 1);
    rd_chk(0, 16'h8000, "R4 reads 0 at end");
    repeat (5) @(negedge clk); #1;
    chk(done_irq[0] == 1, "R9 done sticky", done_irq[0], 1);
    pulse_clr(0); #1;
    chk(done_irq[0] == 0, "R9 done cleared", done_irq[0], 0);

    // R7 exact multiple then trailing empty packet
    wr(1, 16'hC010);
    send(1, 8, "R7 full packet 1");
    send(1, 8, "R7 full packet 2");
    chk(done_irq[1] == 0, "R7 no done before empty packet", done_irq[1], 0);
    send(1, 0, "R7 trailing empty packet");
    chk(done_irq[1] == 1, "R7 done after empty packet", done_irq[1], 1);
    pulse_clr(1);

    // R7 zero size in byte mode
    wr(1, 16'hC000);
    send(1, 0, "R7 zero size empty packet");
    chk(done_irq[1] == 1, "R7 done after single empty packet", done_irq[1], 1);
    pulse_clr(1);

    // R5 buffer mode size 3 with 64-byte buffers
    wr(2, 16'h4003);
    send(2, 64, "R5 buffer packet 1");
    rd_chk(2, 16'h0002, "R5 R4 buffers left 2");
    send(2, 64, "R5 buffer packet 2");
    send(2, 64, "R5 buffer packet 3");
    chk(done_irq[2] == 1, "R5 done after last buffer", done_irq[2], 1);
    pulse_clr(2);

    // R5 zero size means 1024 buffers
    wr(2, 16'h4000);
    rd_chk(2, 16'h0000, "R5 full run reads 0 at start");
    send(2, 64, "R5 full run packet");
    rd_chk(2, 16'h03FF, "R5 full run reads 3FF");
    for (int k = 0; k < 1022; k++) send(2, 64, "R5 full run packet");
    rd_chk(2, 16'h0001, "R5 full run one left");
    chk(done_irq[2] == 0, "R5 no done before 1024th", done_irq[2], 0);
    send(2, 64, "R5 full run last packet");
    chk(done_irq[2] == 1, "R5 done after 1024 buffers", done_irq[2], 1);
    pulse_clr(2);

    // R3 writes ignored while active
    wr(0, 16'hC005);
    wr(0, 16'h4003);
    rd_chk(0, 16'h8005, "R3 write while active ignored");
    send(0, 5, "R3 original size used");
    chk(done_irq[0] == 1, "R3 original transfer completes", done_irq[0], 1);
    pulse_clr(0);

    // R8 second token while pending ignored, stray ack ignored
    wr(0, 16'hC018);
    ack(0); #1;
    rd_chk(0, 16'h8018, "R8 ack without request ignored");
    sb_q.push_back(8); tag_q.push_back("R8 first token length");
    tok(0);
    tok(0);
    ack(0); #1;
    chk(pkt_req[0] == 0, "R8 request drops after ack", pkt_req[0], 0);
    rd_chk(0, 16'h8010, "R8 one decrement per ack");
    repeat (3) @(negedge clk); #1;
    chk(pkt_req[0] == 0, "R8 extra token not queued", pkt_req[0], 0);

    // R12 buffer size sampled at start; R10 abort
    wr(1, 16'hC01E);
    set_bsz(1, 16);
    send(1, 8, "R12 latched buffer size");
    tok(0); #1;
    sb_q.push_back(8); tag_q.push_back("R8 channel 0 packet");
    ep_clr[1] = 1'b1;
    @(negedge clk); ep_clr[1] = 1'b0; #1;
    rd_chk(1, 16'h8000, "R10 size reads 0 after abort");
    chk(done_irq[1] == 0, "R10 no done on abort", done_irq[1], 0);
    tok(1); #1;
    chk(pkt_req[1] == 0, "R10 idle after abort", pkt_req[1], 0);
    set_bsz(1, 8);

    // R11 bus reset with a request pending on channel 0
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0; #1;
    chk(pkt_req == 0 && done_irq == 0, "R11 bus reset outputs", {done_irq, pkt_req}, 0);
    for (int c = 0; c < NCH; c++) rd_chk(c, 16'h0000, "R11 bus reset readback");

    repeat (3) @(negedge clk); #3;
    chk(sb_q.size() == 0, "R8 all expected packets seen", sb_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule